// File: doc/BRIEF.md
# Ethernet Receive Frame Tracker

This block follows a byte-wide Ethernet receive stream, one byte per clock with a data-valid and a receive-error strobe, and walks every frame through its phases: waiting while disabled, idle, preamble, waiting for the start delimiter, destination address, payload with check sequence, and the error path. It decides after the sixth address byte whether the frame is wanted. The station's own address, the all-ones broadcast address, or promiscuous mode admit a frame. Frames that are not wanted are dropped without any output.

Admitted frames are passed on as a byte stream with start and end markers. On the end marker, a one-cycle status word gives the address class, whether the CRC-32 residue was wrong, and whether a receive error was seen during the frame. A frame with a receive error is still passed on in full and is only flagged. An error strobe while the line is idle, with no data valid, is reported as an illegal-carrier status event that carries no data. The bytes are held back by an address-length delay line, so the address decision is made before the first byte leaves the block.

Top module: `erx_frame_ctrl`

## Requirements
- R1: Reset, or `rx_en` low, puts the block in a halted state. From the cycle after `rx_en` is sampled low there is no `out_valid` and no `stat_valid`, and a frame in progress ends without `out_eof`. Line activity while halted produces nothing.
- R2: A frame is recognised only after at least one preamble byte 0x55 followed by the delimiter 0xD5, both with `gm_dv` high. The block ignores the rest of the activity until `gm_dv` drops, with no output, in two cases: any other byte before the delimiter, or a delimiter with no preamble before it.
- R3: The six bytes after the delimiter form the destination address, and the first byte on the wire is `own_addr[47:40]`. A frame is forwarded only if this address equals `own_addr`, is all ones, or `promisc` is high. Any other frame gives no output and no status.
- R4: A forwarded frame appears on `out_data` with `out_valid` high, byte for byte in arrival order. It runs from the first destination address byte to the last byte before `gm_dv` dropped, with the check sequence included. `out_sof` marks the first byte and `out_eof` marks the last.
- R5: `stat_cls` on the end-of-frame status is 2'b01 when the address equals `own_addr`, 2'b10 when it is all ones, and 2'b11 when only promiscuous mode admitted the frame. The own-address match wins over broadcast, and broadcast wins over promiscuous.
- R6: A CRC-32 (reflected polynomial 0xEDB88320, start value all ones, no final inversion) runs over every forwarded byte. `stat_crc_err` is 0 exactly when the final register equals 0xDEBB20E3.
- R7: If `gm_er` is high together with `gm_dv` on any byte after the delimiter, an admitted frame is still forwarded in full, and its status has `stat_rx_err` set.
- R8: In the idle state with `rx_en` high, `gm_dv` low and `gm_er` high give a `stat_valid` pulse in the next cycle. That pulse has `stat_car_err`=1, `stat_cls`=2'b00, and no data byte with it.
- R9: `out_eof` and the end-of-frame `stat_valid` appear exactly 7 cycles after the first cycle in which `gm_dv` is low after a forwarded frame.
- R10: A frame whose `gm_dv` drops before all six address bytes have arrived gives no output and no status.
- R11: `out_sof` is only ever high with `out_valid`. `out_eof` is always high with `out_valid` and `stat_valid`, and never with `stat_car_err`. `out_valid` is low in the cycle after `out_eof`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one byte per cycle |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receiver enable; low halts the machine |
| promisc | input | 1 | Accept every destination address |
| own_addr | input | 48 | Station address, first wire byte in bits 47:40 |
| gm_dv | input | 1 | Receive data valid |
| gm_er | input | 1 | Receive error strobe |
| gm_d | input | 8 | Receive data byte |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_sof | output | 1 | First byte of a frame |
| out_eof | output | 1 | Last byte of a frame |
| stat_valid | output | 1 | Status word valid (end of frame or carrier event) |
| stat_cls | output | 2 | Address class: 01 own, 10 broadcast, 11 promiscuous |
| stat_crc_err | output | 1 | CRC residue mismatch |
| stat_rx_err | output | 1 | Receive error seen during the frame |
| stat_car_err | output | 1 | Illegal carrier seen while idle |

## Verification
Each byte goes through six delay stages and an output register. A payload byte appears 7 cycles after it was presented, and the last six bytes drain out at 8 cycles. The end marker and frame status come 7 cycles after the first cycle with data-valid low, and a carrier event reports 1 cycle after it is presented. The bench records the cycle number at which it lowers data-valid or raises the carrier strobe, and checks the distance to the reported event against these figures. It drives at least 12 idle cycles after each frame, so the drain has finished before the collected bytes and status are compared with values worked out from the frame it built.

// File: rtl/erx_pkg.sv
package erx_pkg;

  typedef enum logic [3:0] {
    ST_HALT,
    ST_IDLE,
    ST_PRE,
    ST_WSFD,
    ST_DADR,
    ST_DATA,
    ST_ERRD,
    ST_ENOT,
    ST_TAIL,
    ST_DROP
  } rx_state_t;

  typedef enum logic [1:0] {
    CLS_NONE  = 2'b00,
    CLS_OWN   = 2'b01,
    CLS_BCAST = 2'b10,
    CLS_PROM  = 2'b11
  } addr_cls_t;

endpackage

// File: rtl/erx_crc32.sv
module erx_crc32 #(
  parameter logic [31:0] POLY = 32'hEDB88320,
  parameter logic [31:0] SEED = 32'hFFFFFFFF
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        init,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [31:0] crc
);

  logic [31:0] nx;

  // bitwise reflected update, least significant data bit first
  always_comb begin
    nx = crc;
    for (int i = 0; i < 8; i++) begin
      if (nx[0] ^ din[i]) nx = (nx >> 1) ^ POLY;
      else                nx = nx >> 1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || init) crc <= SEED;
    else if (en)     crc <= nx;
  end

endmodule

// File: rtl/erx_byte_delay.sv
module erx_byte_delay #(
  parameter int DEPTH = 6,
  parameter int W     = 8,
  localparam int FW   = $clog2(DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   clr,
  input  logic                   push,
  input  logic                   drain,
  input  logic [W-1:0]           din,
  output logic [W-1:0]           dout,
  output logic [(DEPTH-1)*W-1:0] taps,
  output logic [FW-1:0]          fill
);

  logic [W-1:0] sr [DEPTH];

  // plain shift chain without reset, suited to shift-register inference
  always_ff @(posedge clk) begin
    if (push || drain) begin
      sr[0] <= push ? din : '0;
      for (int i = 1; i < DEPTH; i++) sr[i] <= sr[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr)                         fill <= '0;
    else if (push && fill != FW'(DEPTH))    fill <= fill + 1'b1;
    else if (!push && drain && fill != '0)  fill <= fill - 1'b1;
  end

  assign dout = sr[DEPTH-1];

  for (genvar g = 0; g < DEPTH - 1; g++) begin : g_tap
    assign taps[g*W +: W] = sr[g];
  end

endmodule

// File: rtl/erx_addr_match.sv
module erx_addr_match
  import erx_pkg::*;
#(
  parameter int AW = 48
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] own,
  input  logic          promisc,
  output logic [1:0]    cls,
  output logic          pass
);

  always_comb begin
    if (addr == own)           cls = CLS_OWN;
    else if (addr == '1)       cls = CLS_BCAST;
    else if (promisc)          cls = CLS_PROM;
    else                       cls = CLS_NONE;
    pass = (cls != CLS_NONE);
  end

endmodule

// File: rtl/erx_frame_ctrl.sv
module erx_frame_ctrl
  import erx_pkg::*;
#(
  parameter int          ADDR_BYTES  = 6,
  parameter logic [7:0]  PRE_BYTE    = 8'h55,
  parameter logic [7:0]  SFD_BYTE    = 8'hD5,
  parameter logic [31:0] CRC_POLY    = 32'hEDB88320,
  parameter logic [31:0] CRC_RESIDUE = 32'hDEBB20E3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    rx_en,
  input  logic                    promisc,
  input  logic [8*ADDR_BYTES-1:0] own_addr,
  input  logic                    gm_dv,
  input  logic                    gm_er,
  input  logic [7:0]              gm_d,
  output logic                    out_valid,
  output logic [7:0]              out_data,
  output logic                    out_sof,
  output logic                    out_eof,
  output logic                    stat_valid,
  output logic [1:0]              stat_cls,
  output logic                    stat_crc_err,
  output logic                    stat_rx_err,
  output logic                    stat_car_err
);

  localparam int AW = 8 * ADDR_BYTES;
  localparam int FW = $clog2(ADDR_BYTES + 1);

  rx_state_t st, nxt;

  logic                      push, drain, crc_init, crc_en;
  logic [7:0]                dl_out;
  logic [(ADDR_BYTES-1)*8-1:0] taps;
  logic [FW-1:0]             fill;
  logic [31:0]               crc_val;
  logic [AW-1:0]             addr_word;
  logic [1:0]                m_cls;
  logic                      m_pass;
  logic                      last_addr, accept, pop, last_pop;
  logic                      err_seen, sof_pend;
  logic [1:0]                cls_q;
  logic                      in_idle, car_evt;

  // ---------------- datapath pieces ----------------
  erx_byte_delay #(.DEPTH(ADDR_BYTES), .W(8)) i_delay (
    .clk   (clk),
    .rst   (rst),
    .clr   (crc_init || !rx_en),
    .push  (push),
    .drain (drain),
    .din   (gm_d),
    .dout  (dl_out),
    .taps  (taps),
    .fill  (fill)
  );

  erx_crc32 #(.POLY(CRC_POLY), .SEED(32'hFFFFFFFF)) i_crc (
    .clk  (clk),
    .rst  (rst),
    .init (crc_init),
    .en   (crc_en),
    .din  (gm_d),
    .crc  (crc_val)
  );

  // address word: oldest held byte is the first wire byte (most significant)
  always_comb begin
    addr_word[7:0] = gm_d;
    for (int i = 0; i < ADDR_BYTES - 1; i++) addr_word[8*(i+1) +: 8] = taps[8*i +: 8];
  end

  erx_addr_match #(.AW(AW)) i_match (
    .addr    (addr_word),
    .own     (own_addr),
    .promisc (promisc),
    .cls     (m_cls),
    .pass    (m_pass)
  );

  assign in_idle   = (st == ST_IDLE);
  assign last_addr = (fill == FW'(ADDR_BYTES - 1));
  assign car_evt   = in_idle && rx_en && !gm_dv && gm_er;

  // ---------------- next state ----------------
  always_comb begin
    nxt      = st;
    push     = 1'b0;
    drain    = 1'b0;
    crc_init = 1'b0;
    crc_en   = 1'b0;
    accept   = 1'b0;
    case (st)
      ST_HALT: if (rx_en) nxt = ST_IDLE;
      ST_IDLE: if (gm_dv) nxt = (gm_d == PRE_BYTE) ? ST_PRE : ST_DROP;
      ST_PRE, ST_WSFD: begin
        if (!gm_dv)                nxt = ST_IDLE;
        else if (gm_d == PRE_BYTE) nxt = ST_WSFD;
        else if (gm_d == SFD_BYTE) begin
          nxt      = ST_DADR;
          crc_init = 1'b1;
        end
        else                       nxt = ST_DROP;
      end
      ST_DADR: begin
        if (!gm_dv) nxt = ST_IDLE;
        else begin
          push   = 1'b1;
          crc_en = 1'b1;
          if (last_addr) begin
            if (m_pass) begin
              accept = 1'b1;
              nxt    = (err_seen || gm_er) ? ST_ERRD : ST_DATA;
            end else begin
              nxt    = ST_DROP;
            end
          end
        end
      end
      ST_DATA: begin
        if (!gm_dv) nxt = ST_TAIL;
        else begin
          push   = 1'b1;
          crc_en = 1'b1;
          if (gm_er) nxt = ST_ERRD;
        end
      end
      ST_ERRD: begin
        if (!gm_dv) nxt = ST_ENOT;
        else begin
          push   = 1'b1;
          crc_en = 1'b1;
        end
      end
      ST_TAIL, ST_ENOT: begin
        drain = 1'b1;
        if (fill == FW'(1)) nxt = ST_IDLE;
      end
      ST_DROP: if (!gm_dv) nxt = ST_IDLE;
      default: nxt = ST_HALT;
    endcase
    if (!rx_en) begin
      nxt      = ST_HALT;
      push     = 1'b0;
      drain    = 1'b0;
      crc_init = 1'b0;
      crc_en   = 1'b0;
      accept   = 1'b0;
    end
  end

  assign pop      = (push && fill == FW'(ADDR_BYTES)) || drain;
  assign last_pop = drain && (fill == FW'(1));

  // ---------------- state and frame context ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_HALT;
      err_seen <= 1'b0;
      sof_pend <= 1'b0;
      cls_q    <= CLS_NONE;
    end else begin
      st <= nxt;
      if (crc_init)                              err_seen <= 1'b0;
      else if (st == ST_DADR && gm_dv && gm_er)  err_seen <= 1'b1;
      if (accept)                                cls_q <= m_cls;
      if (!rx_en || crc_init)                    sof_pend <= 1'b0;
      else if (accept)                           sof_pend <= 1'b1;
      else if (pop)                              sof_pend <= 1'b0;
    end
  end

  // ---------------- registered outputs ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      out_data     <= '0;
      out_sof      <= 1'b0;
      out_eof      <= 1'b0;
      stat_valid   <= 1'b0;
      stat_cls     <= CLS_NONE;
      stat_crc_err <= 1'b0;
      stat_rx_err  <= 1'b0;
      stat_car_err <= 1'b0;
    end else begin
      out_valid  <= pop;
      out_data   <= dl_out;
      out_sof    <= pop && sof_pend;
      out_eof    <= last_pop;
      stat_valid <= last_pop || car_evt;
      if (last_pop) begin
        stat_cls     <= cls_q;
        stat_crc_err <= (crc_val != CRC_RESIDUE);
        stat_rx_err  <= (st == ST_ENOT);
        stat_car_err <= 1'b0;
      end else if (car_evt) begin
        stat_cls     <= CLS_NONE;
        stat_crc_err <= 1'b0;
        stat_rx_err  <= 1'b0;
        stat_car_err <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/erx_frame_ctrl_chk.sv
module erx_frame_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       rx_en,
  input logic       gm_dv,
  input logic       gm_er,
  input logic       in_idle,
  input logic       out_valid,
  input logic       out_sof,
  input logic       out_eof,
  input logic       stat_valid,
  input logic [1:0] stat_cls,
  input logic       stat_car_err
);

  // R1
  halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !rx_en |=> (!out_valid && !stat_valid));

  // R11
  sof_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    out_sof |-> out_valid);

  // R11
  eof_with_status_chk: assert property (@(posedge clk) disable iff (rst)
    out_eof |-> (out_valid && stat_valid && !stat_car_err));

  // R11
  eof_gap_chk: assert property (@(posedge clk) disable iff (rst)
    out_eof |=> !out_valid);

  // R8
  carrier_report_chk: assert property (@(posedge clk) disable iff (rst)
    (in_idle && rx_en && !gm_dv && gm_er) |=> (stat_valid && stat_car_err));

  // R8
  carrier_no_data_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_valid && stat_car_err) |-> (!out_valid && stat_cls == 2'b00));

  // R5
  eof_class_chk: assert property (@(posedge clk) disable iff (rst)
    out_eof |-> (stat_cls != 2'b00));

endmodule

bind erx_frame_ctrl erx_frame_ctrl_chk i_chk (
  .clk          (clk),
  .rst          (rst),
  .rx_en        (rx_en),
  .gm_dv        (gm_dv),
  .gm_er        (gm_er),
  .in_idle      (in_idle),
  .out_valid    (out_valid),
  .out_sof      (out_sof),
  .out_eof      (out_eof),
  .stat_valid   (stat_valid),
  .stat_cls     (stat_cls),
  .stat_car_err (stat_car_err)
);

// File: tb/test_erx_frame_ctrl.sv
module test_erx_frame_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam logic [47:0] OWN = 48'h02_1A_3C_5E_70_91;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_en = 1'b0;
  logic        promisc = 1'b0;
  logic [47:0] own_addr = OWN;
  logic        gm_dv = 1'b0;
  logic        gm_er = 1'b0;
  logic [7:0]  gm_d = 8'h00;
  logic        out_valid, out_sof, out_eof, stat_valid;
  logic [7:0]  out_data;
  logic [1:0]  stat_cls;
  logic        stat_crc_err, stat_rx_err, stat_car_err;

  erx_frame_ctrl i_erx_frame_ctrl (
    .clk(clk), .rst(rst), .rx_en(rx_en), .promisc(promisc), .own_addr(own_addr),
    .gm_dv(gm_dv), .gm_er(gm_er), .gm_d(gm_d),
    .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof), .out_eof(out_eof),
    .stat_valid(stat_valid), .stat_cls(stat_cls), .stat_crc_err(stat_crc_err),
    .stat_rx_err(stat_rx_err), .stat_car_err(stat_car_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // ---------------- output collector ----------------
  logic [7:0] got_q[$];
  int         sof_n, eof_n, st_n, eof_cyc, st_cyc;
  logic [1:0] g_cls;
  logic       g_crc, g_rxe, g_car;

  always @(negedge clk) begin
    if (out_valid) got_q.push_back(out_data);
    if (out_sof) sof_n++;
    if (out_eof) begin eof_n++; eof_cyc = cyc; end
    if (stat_valid) begin
      st_n++; st_cyc = cyc;
      g_cls = stat_cls; g_crc = stat_crc_err; g_rxe = stat_rx_err; g_car = stat_car_err;
    end
  end

  task automatic clear_mon();
    got_q.delete();
    sof_n = 0; eof_n = 0; st_n = 0; eof_cyc = 0; st_cyc = 0;
    g_cls = 2'b00; g_crc = 1'b0; g_rxe = 1'b0; g_car = 1'b0;
  endtask

  task automatic chk_eq(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- stimulus ----------------
  logic [7:0] body[$];
  int         drop_cyc;

  task automatic drive(input logic dv, input logic er, input logic [7:0] d);
    @(posedge clk); #1;
    gm_dv = dv; gm_er = er; gm_d = d;
  endtask

  function automatic logic [31:0] ref_crc();
    logic [31:0] c;
    logic [7:0]  b;
    c = 32'hFFFFFFFF;
    foreach (body[k]) begin
      b = body[k];
      for (int i = 0; i < 8; i++) begin
        if (c[0] ^ b[i]) c = (c >> 1) ^ 32'hEDB88320;
        else             c = c >> 1;
      end
    end
    return c;
  endfunction

  task automatic build_body(input logic [47:0] da, input int plen, input bit bad_crc);
    logic [31:0] fcs;
    body.delete();
    for (int i = 5; i >= 0; i--) body.push_back(da[8*i +: 8]);
    for (int i = 0; i < 6; i++) body.push_back(8'($urandom));
    for (int i = 0; i < plen; i++) body.push_back(8'($urandom));
    fcs = ~ref_crc();
    for (int i = 0; i < 4; i++) body.push_back(fcs[8*i +: 8]);
    if (bad_crc) body[7] = body[7] ^ 8'h01;
  endtask

  task automatic send(input int npre, input logic [7:0] sfd, input int nbytes, input int err_at);
    for (int i = 0; i < npre; i++) drive(1'b1, 1'b0, 8'h55);
    drive(1'b1, 1'b0, sfd);
    for (int i = 0; i < nbytes; i++) drive(1'b1, (i == err_at), body[i]);
    drive(1'b0, 1'b0, 8'h00);
    drop_cyc = cyc;
    repeat (12) drive(1'b0, 1'b0, 8'h00);
  endtask

  function automatic logic [1:0] exp_cls(input logic [47:0] da, input logic prom, input logic [47:0] own);
    if (da == own)        return 2'b01;
    if (da == '1)         return 2'b10;
    if (prom)             return 2'b11;
    return 2'b00;
  endfunction

  task automatic expect_frame(input string tag, input logic [1:0] cls, input bit crc_e, input bit rxe);
    int mm;
    if (cls == 2'b00) begin
      chk_eq(tag, "bytes of dropped frame", got_q.size(), 0);
      chk_eq(tag, "status of dropped frame", st_n, 0);
    end else begin
      chk_eq("R4", "byte count", got_q.size(), body.size());
      mm = 0;
      foreach (got_q[k]) if (k < body.size() && got_q[k] != body[k]) mm++;
      chk_eq("R4", "byte mismatches", mm, 0);
      chk_eq("R4", "sof count", sof_n, 1);
      chk_eq("R11", "eof count", eof_n, 1);
      chk_eq("R11", "status count", st_n, 1);
      chk_eq("R5", "address class", g_cls, cls);
      chk_eq("R6", "crc error flag", g_crc, crc_e);
      chk_eq("R7", "rx error flag", g_rxe, rxe);
      chk_eq("R9", "eof latency", eof_cyc - drop_cyc, 7);
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, actual hang expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // ---------------- main sequence ----------------
  initial begin
    logic [47:0] da;
    int          plen, err_at, r;
    bit          bad;
    void'($urandom(32'h5EED0042));
    clear_mon();
    repeat (4) drive(1'b0, 1'b0, 8'h00);
    #1;
    // R1 reset state
    chk_eq("R1", "out_valid in reset", out_valid, 0);
    chk_eq("R1", "stat_valid in reset", stat_valid, 0);
    rst = 1'b0;

    // R1 halted: whole frame while disabled
    build_body(OWN, 10, 1'b0);
    clear_mon();
    send(7, 8'hD5, body.size(), -1);
    chk_eq("R1", "bytes while halted", got_q.size(), 0);
    chk_eq("R1", "status while halted", st_n, 0);
    // carrier strobe while halted is ignored
    clear_mon();
    drive(1'b0, 1'b1, 8'h0E);
    repeat (3) drive(1'b0, 1'b0, 8'h00);
    chk_eq("R1", "carrier status while halted", st_n, 0);

    rx_en = 1'b1;
    repeat (3) drive(1'b0, 1'b0, 8'h00);

    // R3 R4 own address, clean frame
    build_body(OWN, 20, 1'b0);
    clear_mon();
    send(7, 8'hD5, body.size(), -1);
    expect_frame("R3", 2'b01, 1'b0, 1'b0);

    // R6 corrupted frame
    build_body(48'hFFFF_FFFF_FFFF, 8, 1'b1);
    clear_mon();
    send(1, 8'hD5, body.size(), -1);
    expect_frame("R6", 2'b10, 1'b1, 1'b0);

    // R3 foreign address without promiscuous mode: dropped
    build_body(48'h0A_0B_0C_0D_0E_0F, 12, 1'b0);
    clear_mon();
    send(7, 8'hD5, body.size(), -1);
    expect_frame("R3", 2'b00, 1'b0, 1'b0);

    // R5 foreign address in promiscuous mode
    promisc = 1'b1;
    build_body(48'h0A_0B_0C_0D_0E_0F, 0, 1'b0);
    clear_mon();
    send(3, 8'hD5, body.size(), -1);
    expect_frame("R5", 2'b11, 1'b0, 1'b0);
    // R5 own address wins over promiscuous
    build_body(OWN, 5, 1'b0);
    clear_mon();
    send(3, 8'hD5, body.size(), -1);
    expect_frame("R5", 2'b01, 1'b0, 1'b0);
    promisc = 1'b0;

    // R5 own address equal to broadcast: own match wins
    own_addr = 48'hFFFF_FFFF_FFFF;
    build_body(48'hFFFF_FFFF_FFFF, 4, 1'b0);
    clear_mon();
    send(7, 8'hD5, body.size(), -1);
    expect_frame("R5", 2'b01, 1'b0, 1'b0);
    own_addr = OWN;

    // R2 bad byte before delimiter
    build_body(OWN, 6, 1'b0);
    clear_mon();
    send(3, 8'h33, body.size(), -1);
    expect_frame("R2", 2'b00, 1'b0, 1'b0);
    // R2 delimiter with no preamble
    clear_mon();
    send(0, 8'hD5, body.size(), -1);
    expect_frame("R2", 2'b00, 1'b0, 1'b0);

    // R10 truncated inside the address
    build_body(OWN, 6, 1'b0);
    clear_mon();
    send(7, 8'hD5, 3, -1);
    expect_frame("R10", 2'b00, 1'b0, 1'b0);

    // R7 error inside payload and inside address
    build_body(OWN, 10, 1'b0);
    clear_mon();
    send(7, 8'hD5, body.size(), 15);
    expect_frame("R7", 2'b01, 1'b0, 1'b1);
    build_body(48'hFFFF_FFFF_FFFF, 3, 1'b0);
    clear_mon();
    send(7, 8'hD5, body.size(), 2);
    expect_frame("R7", 2'b10, 1'b0, 1'b1);

    // R8 illegal carrier while idle
    clear_mon();
    drive(1'b0, 1'b1, 8'h0E);
    r = cyc;
    repeat (3) drive(1'b0, 1'b0, 8'h00);
    chk_eq("R8", "carrier status count", st_n, 1);
    chk_eq("R8", "carrier flag", g_car, 1);
    chk_eq("R8", "carrier class", g_cls, 0);
    chk_eq("R8", "carrier data bytes", got_q.size(), 0);
    chk_eq("R8", "carrier latency", st_cyc - r, 1);

    // R1 enable dropped in mid frame
    build_body(OWN, 30, 1'b0);
    clear_mon();
    for (int i = 0; i < 7; i++) drive(1'b1, 1'b0, 8'h55);
    drive(1'b1, 1'b0, 8'hD5);
    for (int i = 0; i < body.size(); i++) begin
      drive(1'b1, 1'b0, body[i]);
      if (i == 20) rx_en = 1'b0;
    end
    drive(1'b0, 1'b0, 8'h00);
    repeat (12) drive(1'b0, 1'b0, 8'h00);
    chk_eq("R1", "eof after disable", eof_n, 0);
    chk_eq("R1", "status after disable", st_n, 0);
    chk_eq("R1", "bytes cut short", got_q.size() < body.size(), 1);
    rx_en = 1'b1;
    repeat (3) drive(1'b0, 1'b0, 8'h00);
    build_body(OWN, 2, 1'b0);
    clear_mon();
    send(7, 8'hD5, body.size(), -1);
    expect_frame("R1", 2'b01, 1'b0, 1'b0);

    // constrained random frames (R3 R4 R5 R6 R7 R9)
    for (int n = 0; n < 40; n++) begin
      r = int'($urandom % 4);
      if (r == 0)      da = OWN;
      else if (r == 1) da = 48'hFFFF_FFFF_FFFF;
      else begin
        da = {16'($urandom), 32'($urandom)};
        if (da == OWN || da == 48'hFFFF_FFFF_FFFF) da = 48'h0A_0B_0C_0D_0E_0F;
      end
      promisc = ($urandom % 3 == 0);
      plen    = int'($urandom % 21);
      bad     = ($urandom % 4 == 0);
      build_body(da, plen, bad);
      err_at  = ($urandom % 4 == 0) ? int'($urandom % body.size()) : -1;
      clear_mon();
      send(1 + int'($urandom % 7), 8'hD5, body.size(), err_at);
      expect_frame("R3", exp_cls(da, promisc, OWN), bad, err_at >= 0);
    end
    promisc = 1'b0;

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule